// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a small processor core that runs one instruction per clock for a seven-instruction subset of a 32-bit load/store RISC instruction set. The subset is add, sub, ori, lw, sw, beq and j. A 32-entry register file, an ALU with a zero flag, an immediate extender and a word-addressed data memory are all held inside the core. One combinational decoder steers the writeback selection, the ALU operand source and the extension mode. The program counter, the register file and the data memory all update on the same rising clock edge.

The instruction memory is an internal word array. It is filled through a simple write port, normally while reset is held. A debug read port and the program counter are brought out so that a bench can watch the architectural state as the program runs. An opcode outside the subset is executed as a no-op.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, sets the PC to 0 and clears every register to 0.
- R2: R-type (opcode 0, shamt 0) with funct 0x20 writes rs+rt into rd, and with funct 0x22 writes rs-rt into rd. Both advance the PC by 4.
- R3: ori (opcode 0x0D) writes rs OR the 16-bit immediate into rt. The immediate is zero-extended, so bit 15 of the immediate does not spread into bits 31..16.
- R4: lw (opcode 0x23) loads the data-memory word at rs + sign-extended imm16 into rt. A negative offset subtracts from the base.
- R5: sw (opcode 0x2B) writes rt into the data-memory word at rs + sign-extended imm16 and writes no register.
- R6: beq (opcode 0x04) sets the PC to PC+4 + (sign-extended imm16 × 4) when rs equals rt, and to PC+4 otherwise. Negative offsets branch backward.
- R7: j (opcode 0x02) sets the PC to the upper 4 bits of PC+4, followed by the 26-bit target, followed by two zero bits.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: Any other opcode, and any R-type word with another funct or a nonzero shamt, writes no register and no memory, and the PC advances by 4.
- R10: The debug read port returns the current value of the selected register combinationally, and the `pc` output shows the address of the instruction now executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state element updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction-memory load strobe |
| imem_waddr | input | IA | Word index of the instruction to load |
| imem_wdata | input | 32 | Instruction word to load |
| dbg_raddr | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Value of the selected register |
| pc | output | 32 | Byte address of the instruction now executing |

## Verification
The bench runs a short program step by step and checks the PC and one register after every clock. This separates sequential, taken-branch, untaken-branch, backward-branch and jump updates of the PC. The ori immediate has bit 15 set, so zero extension and sign extension give different results. The subtraction gives a negative result, which catches a swapped operand order. The store and the later load use base registers that differ, and the load uses a negative offset, so address formation is exercised in both directions. A write aimed at register 0, an unknown opcode whose rt field names a live register, and the skipped instructions after taken branches and jumps show that nothing is written where nothing may be.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA = $clog2(IMEM_WORDS),
  localparam int DA = $clog2(DMEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          imem_we,
  input  logic [IA-1:0] imem_waddr,
  input  logic [31:0]   imem_wdata,
  input  logic [4:0]    dbg_raddr,
  output logic [31:0]   dbg_rdata,
  output logic [31:0]   pc
);
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;

  localparam logic [1:0] ALU_ADD = 2'd0;
  localparam logic [1:0] ALU_SUB = 2'd1;
  localparam logic [1:0] ALU_OR  = 2'd2;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf_q [32];
  logic [31:0] pc_q;

  logic [31:0] instr;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, shamt;
  logic [15:0] imm16;
  logic [25:0] tgt;

  assign instr = imem[pc_q[IA+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign shamt = instr[10:6];
  assign funct = instr[5:0];
  assign imm16 = instr[15:0];
  assign tgt   = instr[25:0];

  logic       reg_wr, mem_wr, branch, jump, ext_sign, alu_imm, dst_rd, wb_mem, known;
  logic [1:0] alu_ctl;

  always_comb begin
    reg_wr   = 1'b0;
    mem_wr   = 1'b0;
    branch   = 1'b0;
    jump     = 1'b0;
    ext_sign = 1'b0;
    alu_imm  = 1'b0;
    dst_rd   = 1'b0;
    wb_mem   = 1'b0;
    known    = 1'b1;
    alu_ctl  = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        dst_rd = 1'b1;
        if (shamt == 5'd0 && funct == FN_ADD) begin
          reg_wr = 1'b1;
        end else if (shamt == 5'd0 && funct == FN_SUB) begin
          reg_wr  = 1'b1;
          alu_ctl = ALU_SUB;
        end else begin
          known = 1'b0;
        end
      end
      OP_ORI: begin
        reg_wr  = 1'b1;
        alu_imm = 1'b1;
        alu_ctl = ALU_OR;
      end
      OP_LW: begin
        reg_wr   = 1'b1;
        alu_imm  = 1'b1;
        ext_sign = 1'b1;
        wb_mem   = 1'b1;
      end
      OP_SW: begin
        mem_wr   = 1'b1;
        alu_imm  = 1'b1;
        ext_sign = 1'b1;
      end
      OP_BEQ: begin
        branch   = 1'b1;
        ext_sign = 1'b1;
        alu_ctl  = ALU_SUB;
      end
      OP_J: jump = 1'b1;
      default: known = 1'b0;
    endcase
  end

  logic [31:0] bus_a, bus_b, ext_imm, alu_b, alu_y, mem_q, bus_w;
  logic [4:0]  rw;
  logic        zero;

  assign bus_a   = (rs == 5'd0) ? 32'd0 : rf_q[rs];
  assign bus_b   = (rt == 5'd0) ? 32'd0 : rf_q[rt];
  assign ext_imm = ext_sign ? {{16{imm16[15]}}, imm16} : {16'd0, imm16};
  assign alu_b   = alu_imm ? ext_imm : bus_b;

  always_comb begin
    unique case (alu_ctl)
      ALU_SUB: alu_y = bus_a - alu_b;
      ALU_OR:  alu_y = bus_a | alu_b;
      default: alu_y = bus_a + alu_b;
    endcase
  end
  assign zero = (alu_y == 32'd0);

  assign mem_q = dmem[alu_y[DA+1:2]];
  assign bus_w = wb_mem ? mem_q : alu_y;
  assign rw    = dst_rd ? rd : rt;

  logic [31:0] pc_plus4, br_ofs, pc_next;
  logic        take;
  assign pc_plus4 = pc_q + 32'd4;
  assign br_ofs   = {ext_imm[29:0], 2'b00};
  assign take     = branch & zero;
  assign pc_next  = jump ? {pc_plus4[31:28], tgt, 2'b00}
                  : take ? pc_plus4 + br_ofs
                  : pc_plus4;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst && mem_wr) dmem[alu_y[DA+1:2]] <= bus_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= 32'd0;
      for (int i = 0; i < 32; i++) rf_q[i] <= 32'd0;
    end else begin
      pc_q <= pc_next;
      if (reg_wr && rw != 5'd0) rf_q[rw] <= bus_w;
    end
  end

  assign dbg_rdata = (dbg_raddr == 5'd0) ? 32'd0 : rf_q[dbg_raddr];
  assign pc        = pc_q;

  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc_q == 32'd0));

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst) rf_q[0] == 32'd0);

  a_r5_store_no_regwr: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !reg_wr);

  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!reg_wr && !mem_wr));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!jump && !take) |=> (pc_q == $past(pc_q) + 32'd4));

  a_r6_branch_target: assert property (@(posedge clk) disable iff (rst)
    take |=> (pc_q == $past(pc_plus4 + br_ofs)));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    jump |=> (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_plus4[31:28])));
endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
  localparam int IW = 64;
  localparam int IA = $clog2(IW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          imem_we = 1'b0;
  logic [IA-1:0] imem_waddr = '0;
  logic [31:0]   imem_wdata = '0;
  logic [4:0]    dbg_raddr = '0;
  logic [31:0]   dbg_rdata, pc;

  always #2.5 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(64)) u_sc_core (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata), .pc(pc)
  );

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input int f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
  endfunction
  function automatic logic [31:0] enc_i(input int o, input int s, input int t, input int imm);
    return {6'(o), 5'(s), 5'(t), 16'(imm)};
  endfunction

  localparam int NP = 20;
  localparam logic [31:0] PROG [NP] = '{
    enc_i(13, 0, 1, 32'h0005),
    enc_i(13, 0, 2, 32'h8001),
    enc_r(1, 2, 3, 32),
    enc_r(1, 2, 4, 34),
    enc_i(13, 0, 5, 32'h0010),
    enc_i(43, 5, 3, 4),
    enc_i(13, 0, 7, 32'h0018),
    enc_i(35, 7, 6, 32'hFFFC),
    enc_r(1, 1, 0, 32),
    32'hFC21_FFFF,
    enc_i(4, 1, 2, 5),
    enc_i(4, 3, 6, 2),
    enc_i(13, 0, 9, 1),
    enc_i(13, 0, 9, 2),
    enc_i(13, 0, 9, 7),
    {6'h02, 26'd18},
    enc_i(13, 0, 10, 32'h0BAD),
    enc_i(13, 0, 10, 32'h0BAD),
    enc_i(13, 0, 10, 3),
    enc_i(4, 0, 0, 32'hFFFE)
  };

  typedef struct packed {
    logic [31:0] epc;
    logic [4:0]  rg;
    logic [31:0] val;
    logic [7:0]  req;
  } chk_t;

  localparam int NC = 17;
  localparam chk_t CHK [NC] = '{
    '{32'd4,  5'd1,  32'h0000_0005, 8'd3},
    '{32'd8,  5'd2,  32'h0000_8001, 8'd3},
    '{32'd12, 5'd3,  32'h0000_8006, 8'd2},
    '{32'd16, 5'd4,  32'hFFFF_8004, 8'd2},
    '{32'd20, 5'd5,  32'h0000_0010, 8'd3},
    '{32'd24, 5'd3,  32'h0000_8006, 8'd5},
    '{32'd28, 5'd7,  32'h0000_0018, 8'd3},
    '{32'd32, 5'd6,  32'h0000_8006, 8'd4},
    '{32'd36, 5'd0,  32'h0000_0000, 8'd8},
    '{32'd40, 5'd1,  32'h0000_0005, 8'd9},
    '{32'd44, 5'd2,  32'h0000_8001, 8'd6},
    '{32'd56, 5'd9,  32'h0000_0000, 8'd6},
    '{32'd60, 5'd9,  32'h0000_0007, 8'd6},
    '{32'd72, 5'd10, 32'h0000_0000, 8'd7},
    '{32'd76, 5'd10, 32'h0000_0003, 8'd10},
    '{32'd72, 5'd10, 32'h0000_0003, 8'd6},
    '{32'd76, 5'd10, 32'h0000_0003, 8'd6}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      imem_we = 1'b1;
      imem_waddr = IA'(i);
      imem_wdata = PROG[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    @(negedge clk);
    check("R1", "pc after reset", pc, 32'd0);
    dbg_raddr = 5'd1;
    #0.1 check("R1", "r1 after reset", dbg_rdata, 32'd0);
    dbg_raddr = 5'd31;
    #0.1 check("R1", "r31 after reset", dbg_rdata, 32'd0);

    rst = 1'b0;
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      dbg_raddr = CHK[c].rg;
      #0.1;
      check($sformatf("R%0d", CHK[c].req), $sformatf("step %0d pc", c), pc, CHK[c].epc);
      check($sformatf("R%0d", CHK[c].req), $sformatf("step %0d reg %0d", c, CHK[c].rg), dbg_rdata, CHK[c].val);
    end

    // R10: debug port sees earlier results without any clock
    dbg_raddr = 5'd4;
    #0.1 check("R10", "debug read r4", dbg_rdata, 32'hFFFF_8004);
    dbg_raddr = 5'd6;
    #0.1 check("R10", "debug read r6", dbg_rdata, 32'h0000_8006);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pc after mid-run reset", pc, 32'd0);
    dbg_raddr = 5'd10;
    #0.1 check("R1", "r10 after mid-run reset", dbg_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    dbg_raddr = 5'd1;
    #0.1;
    check("R2", "pc after restart", pc, 32'd4);
    check("R3", "r1 after restart", dbg_rdata, 32'd5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule